// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the column path of a two-bank synchronous graphics memory. It holds the burst configuration and turns each read or write start into a run of column addresses, one per enabled clock. The configuration comes from a packed mode word on an 11-bit address bus. Loading it is a separate command, accepted only while both banks are idle. After an accepted load, the block refuses further starts and loads for two enabled cycles.

A start latches an 8-bit start column. The block then steps through the burst in one of two orders. Sequential order counts up and wraps inside an aligned block of the burst length. Interleaved order XORs the start column with the beat count. A 256-beat full-page burst walks the whole column space in sequential order. The final beat is flagged. A terminate input ends a burst early. A new start replaces the running burst at once. The configured CAS latency is brought out so that read-data timing downstream can use it.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last, cfg_err and cmd_busy are low. The configuration is burst length 1, sequential order and CAS latency 2, so cas_lat reads 2.
- R2: Mode word bits 2..0 select the burst length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is 256 (full page). A burst drives col_valid for exactly that many beats.
- R3: When mode word bit 3 is 0 (sequential), beat i carries the low log2(length) bits of (start + i), and the upper column bits keep the start column's value. Length 4 from column 0xA2 gives 0xA2, 0xA3, 0xA0, 0xA1.
- R4: When mode word bit 3 is 1 (interleaved), the low log2(length) bits of beat i are the start column XOR i. Length 8 from column 0x35 gives 0x35, 0x34, 0x37, 0x36, 0x31, 0x30, 0x33, 0x32.
- R5: A full-page burst gives (start + i) mod 256 for i from 0 to 255. A mode word that asks for full page with interleaved order is rejected under R7.
- R6: Mode word bits 6..4 select the CAS latency: 010 gives cas_lat 2 and 011 gives cas_lat 3. Bits 10..7 are ignored.
- R7: An accepted load whose burst-length code or latency code is reserved, or that asks for full page with interleaved order, raises cfg_err for one cycle. The previous configuration stays in force.
- R8: A load while banks_idle is low is ignored. cmd_busy and cfg_err stay low and the configuration is unchanged.
- R9: After an accepted load, cmd_busy is high for two enabled cycles. A start or load in that window is ignored.
- R10: col_last is high on the final beat only. col_valid drops on the next enabled cycle unless a new start arrives.
- R11: A stop on an enabled cycle with no start ends the running burst. col_valid is low from the next cycle.
- R12: A start during a burst restarts at once. The next cycle shows beat 0 at the new column, and the new burst follows the current configuration.
- R13: While en is low, all state holds: outputs keep their values, and start, stop and load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for all state |
| cfg_load | input | 1 | Mode register set command |
| cfg_word | input | 11 | Packed mode word |
| banks_idle | input | 1 | Both banks idle |
| start | input | 1 | Read or write start |
| start_col | input | 8 | Start column of the burst |
| stop | input | 1 | Burst terminate |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is present on col_out |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Configured CAS latency (2 or 3) |
| cfg_err | output | 1 | The previous load carried a rejected code |
| cmd_busy | output | 1 | Start and load are being refused |

## Verification
The embedded properties assume that en is a clean, known level on every edge and that a start or stop is held for just one cycle. The bench drives every input a short time after the rising edge and keeps en high except in the freeze scenario. The properties also assume that a load is not issued while a burst runs, since banks_idle would be low in a real system. The stimulus therefore issues each load only with no burst in flight, apart from the loads it deliberately refuses in the busy window.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W = 8;

  typedef enum logic [0:0] {ORD_SEQ = 1'b0, ORD_INTLV = 1'b1} order_e;

  typedef struct packed {
    logic [COL_W-1:0] mask;   // low bits that step during a burst
    order_e           order;
    logic             lat3;   // 1: latency 3, 0: latency 2
  } mode_t;

  typedef struct packed {
    logic  ok;
    mode_t m;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [6:0] f);
    mode_dec_t d;
    d.ok      = 1'b1;
    d.m.order = order_e'(f[3]);
    d.m.lat3  = 1'b0;
    case (f[2:0])
      3'b000:  d.m.mask = '0;
      3'b001:  d.m.mask = COL_W'(1);
      3'b010:  d.m.mask = COL_W'(3);
      3'b011:  d.m.mask = COL_W'(7);
      3'b111:  d.m.mask = '1;
      default: begin d.m.mask = '0; d.ok = 1'b0; end
    endcase
    case (f[6:4])
      3'b010:  d.m.lat3 = 1'b0;
      3'b011:  d.m.lat3 = 1'b1;
      default: d.ok = 1'b0;
    endcase
    if (f[2:0] == 3'b111 && f[3]) d.ok = 1'b0;
    return d;
  endfunction
endpackage

// File: rtl/bcg_cfg.sv
module bcg_cfg import bcg_pkg::*; #(
  parameter int CFG_W    = 11,
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CFG_W-1:0] word,
  input  logic             banks_idle,
  output mode_t            mode,
  output logic             busy,
  output logic             err
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [BW-1:0] busy_q, busy_d;
  mode_t         mode_q, mode_d;
  logic          err_q, err_d;
  mode_dec_t     dec;
  logic          acc;

  assign dec = decode_mode(word[6:0]);
  assign acc = en && load && banks_idle && (busy_q == '0);

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    busy_d = busy_q;
    if (en) begin
      err_d = 1'b0;
      if (busy_q != '0) busy_d = busy_q - BW'(1);
      if (acc) begin
        busy_d = BW'(BUSY_CYC);
        if (dec.ok) mode_d = dec.m;
        else        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{mask: '0, order: ORD_SEQ, lat3: 1'b0};
      err_q  <= 1'b0;
      busy_q <= '0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
      busy_q <= busy_d;
    end
  end

  assign mode = mode_q;
  assign busy = (busy_q != '0);
  assign err  = err_q;

  a_r9_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  a_r7_reject_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dec.ok) |=> ($stable(mode_q) && err_q));
  a_r8_not_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !banks_idle && !busy) |=> ($stable(mode_q) && !err_q && !busy));
  a_r5_no_fullpage_intlv: assert property (@(posedge clk) disable iff (!rst_n)
    !((mode_q.mask == '1) && (mode_q.order == ORD_INTLV)));
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq import bcg_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic             busy,
  input  mode_t            mode,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] cnt,
  output logic [COL_W-1:0] mask,
  output order_e           order
);
  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d, cnt_q, cnt_d, mask_q, mask_d;
  order_e           ord_q, ord_d;
  logic             go;

  assign go   = en && start && !busy;
  assign last = act_q && (cnt_q == mask_q);

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    ord_d  = ord_q;
    if (go) begin
      act_d  = 1'b1;
      base_d = start_col;
      cnt_d  = '0;
      mask_d = mode.mask;
      ord_d  = mode.order;
    end else if (en && act_q) begin
      if (stop || last) act_d = 1'b0;
      else              cnt_d = cnt_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      ord_q  <= ORD_SEQ;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      ord_q  <= ord_d;
    end
  end

  assign active = act_q;
  assign base   = base_q;
  assign cnt    = cnt_q;
  assign mask   = mask_q;
  assign order  = ord_q;

  a_r10_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last && !go) |=> !act_q);
  a_r11_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop && !go) |=> !act_q);
  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (act_q && (cnt_q == '0) && (base_q == $past(start_col))));
  a_r13_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(act_q) && $stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr import bcg_pkg::*; (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + cnt;

  for (genvar i = 0; i < COL_W; i++) begin : g_lane
    always_comb begin
      if (!mask[i])                col[i] = base[i];
      else if (order == ORD_INTLV) col[i] = base[i] ^ cnt[i];
      else                         col[i] = sum[i];
    end
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen import bcg_pkg::*; #(
  parameter int CFG_W    = 11,
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             banks_idle,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic             cfg_err,
  output logic             cmd_busy
);
  mode_t            mode;
  logic             busy;
  logic             active, last;
  logic [COL_W-1:0] base, cnt, mask;
  order_e           order;

  bcg_cfg #(.CFG_W(CFG_W), .BUSY_CYC(BUSY_CYC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .load(cfg_load), .word(cfg_word),
    .banks_idle(banks_idle), .mode(mode), .busy(busy), .err(cfg_err)
  );

  bcg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .start_col(start_col),
    .stop(stop), .busy(busy), .mode(mode), .active(active), .last(last),
    .base(base), .cnt(cnt), .mask(mask), .order(order)
  );

  bcg_addr u_addr (
    .base(base), .cnt(cnt), .mask(mask), .order(order), .col(col_out)
  );

  assign col_valid = active;
  assign col_last  = last;
  assign cas_lat   = mode.lat3 ? 2'd3 : 2'd2;
  assign cmd_busy  = busy;

  a_r3_high_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (en && col_valid && !col_last && !stop && !start)
      |=> (((col_out ^ $past(col_out)) & ~mask) == '0));
  a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
  logic        clk = 1'b0;
  logic        rst_n, en, cfg_load, banks_idle, start, stop;
  logic [10:0] cfg_word;
  logic [7:0]  start_col;
  logic [7:0]  col_out;
  logic        col_valid, col_last, cfg_err, cmd_busy;
  logic [1:0]  cas_lat;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .banks_idle(banks_idle), .start(start), .start_col(start_col), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .cas_lat(cas_lat), .cfg_err(cfg_err), .cmd_busy(cmd_busy)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // load a mode word; err seen on the cycle after the load is returned
  task automatic load_cfg(input logic [10:0] w, output logic err_seen);
    cfg_load = 1'b1; cfg_word = w;
    tick();
    cfg_load = 1'b0;
    err_seen = cfg_err;
    tick(); tick();
  endtask

  // issue a start and follow the whole burst, checking every beat
  task automatic run_burst(input string tag, input logic [7:0] s, input int len,
                           input bit intlv);
    logic [7:0] m, e;
    m = 8'(len - 1);
    start = 1'b1; start_col = s;
    tick();
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (intlv) e = (s & ~m) | ((s ^ 8'(i)) & m);
      else       e = (s & ~m) | ((s + 8'(i)) & m);
      check({tag, " col"}, int'(col_out), int'(e));
      check({tag, " valid"}, int'(col_valid), 1);
      check({tag, " last"}, int'(col_last), int'(i == len - 1));
      tick();
    end
    check({tag, " valid drop"}, int'(col_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(col_valid), 0);
    check("R1 last", int'(col_last), 0);
    check("R1 err", int'(cfg_err), 0);
    check("R1 busy", int'(cmd_busy), 0);
    check("R1 cas_lat", int'(cas_lat), 2);
    run_burst("R1 length1", 8'h5C, 1, 1'b0);
  endtask

  task automatic t_seq4();
    logic e;
    load_cfg(11'b1111_011_0_010, e); // upper bits ignored, lat3 seq bl4
    check("R6 no err", int'(e), 0);
    check("R6 cas_lat 3", int'(cas_lat), 3);
    start = 1'b1; start_col = 8'hA2;
    tick(); start = 1'b0;
    check("R3 beat0", int'(col_out), 'hA2); tick();
    check("R3 beat1", int'(col_out), 'hA3); tick();
    check("R3 beat2", int'(col_out), 'hA0);
    check("R10 not last", int'(col_last), 0); tick();
    check("R3 beat3", int'(col_out), 'hA1);
    check("R10 last", int'(col_last), 1); tick();
    check("R10 ended", int'(col_valid), 0);
  endtask

  task automatic t_lengths();
    logic e;
    load_cfg(11'b0000_010_0_000, e);
    run_burst("R2 len1", 8'h17, 1, 1'b0);
    load_cfg(11'b0000_010_0_001, e);
    run_burst("R2 len2", 8'h17, 2, 1'b0);
    load_cfg(11'b0000_010_0_011, e);
    run_burst("R2 len8", 8'h6D, 8, 1'b0);
    check("R6 cas_lat 2", int'(cas_lat), 2);
  endtask

  task automatic t_intlv();
    logic e;
    logic [7:0] exp8 [8] = '{8'h35, 8'h34, 8'h37, 8'h36, 8'h31, 8'h30, 8'h33, 8'h32};
    load_cfg(11'b0000_011_1_011, e);
    start = 1'b1; start_col = 8'h35;
    tick(); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check("R4 intlv8", int'(col_out), int'(exp8[i]));
      tick();
    end
    check("R4 ended", int'(col_valid), 0);
    load_cfg(11'b0000_011_1_010, e);
    run_burst("R4 intlv4", 8'hC9, 4, 1'b1);
  endtask

  task automatic t_fullpage();
    logic e;
    load_cfg(11'b0000_010_0_111, e);
    check("R5 accepted", int'(e), 0);
    run_burst("R5 fullpage", 8'hFE, 256, 1'b0);
  endtask

  task automatic t_reserved();
    logic e;
    // configuration now: full page, latency 2
    load_cfg(11'b0000_011_0_100, e);
    check("R7 bl reserved err", int'(e), 1);
    load_cfg(11'b0000_001_0_010, e);
    check("R7 cl reserved err", int'(e), 1);
    check("R7 cas_lat kept", int'(cas_lat), 2);
    load_cfg(11'b0000_011_1_111, e);
    check("R5 fullpage intlv err", int'(e), 1);
    check("R7 err one cycle", int'(cfg_err), 0);
    run_burst("R7 mode kept", 8'h03, 256, 1'b0);
  endtask

  task automatic t_not_idle();
    logic e;
    banks_idle = 1'b0;
    load_cfg(11'b0000_011_0_001, e);
    banks_idle = 1'b1;
    check("R8 no err", int'(e), 0);
    check("R8 cas_lat kept", int'(cas_lat), 2);
    cfg_load = 1'b1; banks_idle = 1'b0; cfg_word = 11'b0000_011_0_001;
    tick(); cfg_load = 1'b0; banks_idle = 1'b1;
    check("R8 no busy", int'(cmd_busy), 0);
    run_burst("R8 mode kept", 8'h80, 256, 1'b0);
  endtask

  task automatic t_busy();
    cfg_load = 1'b1; cfg_word = 11'b0000_010_0_010;
    tick(); cfg_load = 1'b0;
    check("R9 busy 1", int'(cmd_busy), 1);
    start = 1'b1; start_col = 8'h44;
    tick(); start = 1'b0;
    check("R9 busy 2", int'(cmd_busy), 1);
    check("R9 start refused", int'(col_valid), 0);
    cfg_load = 1'b1; cfg_word = 11'b0000_011_0_010;
    tick(); cfg_load = 1'b0;
    check("R9 busy over", int'(cmd_busy), 0);
    check("R9 load refused", int'(cas_lat), 2);
    run_burst("R9 after window", 8'h44, 4, 1'b0);
  endtask

  task automatic t_stop();
    logic e;
    load_cfg(11'b0000_010_0_011, e);
    start = 1'b1; start_col = 8'h20;
    tick(); start = 1'b0;
    tick();
    check("R11 beat1", int'(col_out), 'h21);
    stop = 1'b1;
    tick(); stop = 1'b0;
    check("R11 stopped", int'(col_valid), 0);
    tick();
    check("R11 stays idle", int'(col_valid), 0);
  endtask

  task automatic t_restart();
    start = 1'b1; start_col = 8'h10;
    tick();
    check("R12 first", int'(col_out), 'h10);
    start_col = 8'h47;
    tick(); start = 1'b0;
    check("R12 new col", int'(col_out), 'h47);
    check("R12 valid", int'(col_valid), 1);
    tick();
    check("R12 wrap", int'(col_out), 'h40);
    for (int i = 0; i < 6; i++) tick();
    check("R12 last", int'(col_last), 1);
    tick();
    check("R12 done", int'(col_valid), 0);
  endtask

  task automatic t_freeze();
    start = 1'b1; start_col = 8'h2B;
    tick(); start = 1'b0;
    tick();
    check("R13 pre", int'(col_out), 'h2C);
    en = 1'b0;
    stop = 1'b1; start = 1'b1; start_col = 8'h99; cfg_load = 1'b1;
    cfg_word = 11'b0000_011_0_000;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R13 held col", int'(col_out), 'h2C);
      check("R13 held valid", int'(col_valid), 1);
    end
    check("R13 no busy", int'(cmd_busy), 0);
    stop = 1'b0; start = 1'b0; cfg_load = 1'b0;
    en = 1'b1;
    tick();
    check("R13 resume", int'(col_out), 'h2D);
    check("R13 cas_lat", int'(cas_lat), 2);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; cfg_load = 1'b0; cfg_word = '0;
    banks_idle = 1'b1; start = 1'b0; start_col = '0; stop = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_seq4();
    t_lengths();
    t_intlv();
    t_fullpage();
    t_reserved();
    t_not_idle();
    t_busy();
    t_stop();
    t_restart();
    t_freeze();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule